// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This unit is the hazard control for a five-stage in-order pipeline: fetch, decode with register read, execute, memory access and writeback. Each cycle it compares the source register numbers of the instruction in decode with the destination of the two older instructions in execute and memory. For each source it chooses where the operand is taken from: the register file, the result leaving execute, or the value in the memory stage.

The unit is purely combinational. When several older instructions write the same register, the youngest one supplies the value. A producer that writes register zero, or that writes no register, is ignored. A writeback-stage producer needs no input here, because the register file makes a same-cycle write visible to the read.

An operand can come from a load that is still in execute. Its data does not exist yet, so the unit raises a stall, which holds fetch and decode. In the same cycle it raises a bubble, which puts a no-op into execute. On the next cycle the load sits in the memory stage and the same comparison selects the memory path. The `clk` and `rst` ports serve only the bound property checks.

Top module: `fwd_stall_unit`

## Requirements
- R1: A source that matches no qualifying producer gets select code 00, which means the register file.
- R2: A source that matches a non-load producer in execute gets select code 01, which means the execute result.
- R3: A source that matches a producer in memory, and no producer in execute, gets select code 10, which means the memory-stage value. This holds whether that producer is a load or not.
- R4: When the execute and memory producers both match a source, the execute producer wins and the code is 01.
- R5: A producer whose destination is register 0 never matches any source.
- R6: A producer whose write flag is low never matches any source.
- R7: When a load in execute matches any source, stall is 1. In that cycle every select code is 00.
- R8: The bubble output equals the stall output in every cycle. Both are 0 unless R7 applies.
- R9: Each source is resolved on its own. Two sources may carry different codes in the same cycle, and code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bound property checks |
| rst | input | 1 | Synchronous active-high reset; disables the checks |
| dec_src | input | N_SRC*5 | Source register numbers of the decode instruction; index i is source i |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination register of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| src_sel | output | N_SRC*2 | Per-source select code: 00 register file, 01 execute, 10 memory |
| hold_fd | output | 1 | Stall: hold fetch and decode |
| ex_bubble | output | 1 | Insert a no-op into execute |

## Verification
Every output is a direct function of the present inputs, so a wrong comparison or priority shows up on `src_sel` in the very cycle the triggering pattern is applied. No earlier history is needed. Random vectors draw register numbers from a small pool, including register zero, so that matches, double matches and load-use cases come up often. Directed cases follow a load through execute and then into memory, to confirm that the stall lasts one cycle and that the memory path is chosen next.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EX  = 2'b01,
        SEL_MEM = 2'b10
    } sel_e;

    typedef struct packed {
        logic              wen;
        logic              load;
        logic [REG_AW-1:0] dst;
    } prod_t;

    // A producer qualifies only if it writes a nonzero register.
    function automatic logic prod_writes(input prod_t p);
        return p.wen && (p.dst != '0);
    endfunction
endpackage

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  prod_t             prod,
    output logic              hit
);
    always_comb hit = prod_writes(prod) && (prod.dst == src);
endmodule

// File: rtl/hz_src_pick.sv
module hz_src_pick
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  prod_t             ex_p,
    input  prod_t             mem_p,
    output sel_e              sel,
    output logic              load_use
);
    logic ex_hit, mem_hit;

    hz_match u_ex  (.src(src), .prod(ex_p),  .hit(ex_hit));
    hz_match u_mem (.src(src), .prod(mem_p), .hit(mem_hit));

    always_comb begin
        load_use = ex_hit && ex_p.load;
        if (ex_hit)       sel = SEL_EX;
        else if (mem_hit) sel = SEL_MEM;
        else              sel = SEL_RF;
    end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import hz_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_SRC-1:0][REG_AW-1:0] dec_src,
    input  logic [REG_AW-1:0]            ex_dst,
    input  logic                         ex_wen,
    input  logic                         ex_load,
    input  logic [REG_AW-1:0]            mem_dst,
    input  logic                         mem_wen,
    output logic [N_SRC-1:0][1:0]        src_sel,
    output logic                         hold_fd,
    output logic                         ex_bubble
);
    prod_t ex_p, mem_p;
    sel_e  pick     [N_SRC];
    logic [N_SRC-1:0] lu_vec;

    always_comb begin
        ex_p  = '{wen: ex_wen,  load: ex_load, dst: ex_dst};
        mem_p = '{wen: mem_wen, load: 1'b0,    dst: mem_dst};
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        hz_src_pick u_pick (
            .src      (dec_src[i]),
            .ex_p     (ex_p),
            .mem_p    (mem_p),
            .sel      (pick[i]),
            .load_use (lu_vec[i])
        );
        // While stalled the decode instruction is replayed, so read the file.
        always_comb src_sel[i] = hold_fd ? SEL_RF : pick[i];
    end

    always_comb begin
        hold_fd   = |lu_vec;
        ex_bubble = hold_fd;
    end
endmodule

// File: rtl/fwd_stall_unit_chk.sv
module fwd_stall_unit_chk
    import hz_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_SRC-1:0][REG_AW-1:0] dec_src,
    input logic [REG_AW-1:0]            ex_dst,
    input logic                         ex_wen,
    input logic                         ex_load,
    input logic [REG_AW-1:0]            mem_dst,
    input logic                         mem_wen,
    input logic [N_SRC-1:0][1:0]        src_sel,
    input logic                         hold_fd,
    input logic                         ex_bubble
);
    assert_bubble_tracks_stall_R8: assert property (@(posedge clk) disable iff (rst)
        hold_fd == ex_bubble);

    assert_stall_needs_ex_load_R7: assert property (@(posedge clk) disable iff (rst)
        hold_fd |-> (ex_load && ex_wen && ex_dst != '0));

    assert_stall_zero_sel_R7: assert property (@(posedge clk) disable iff (rst)
        hold_fd |-> (src_sel == '0));

    assert_no_wen_no_match_R6: assert property (@(posedge clk) disable iff (rst)
        (!ex_wen && !mem_wen) |-> (!hold_fd && src_sel == '0));

    assert_reg0_no_match_R5: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0 && mem_dst == '0) |-> (!hold_fd && src_sel == '0));

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        assert_ex_alu_fwd_R2: assert property (@(posedge clk) disable iff (rst)
            (ex_wen && !ex_load && ex_dst != '0 && ex_dst == dec_src[i])
            |-> (src_sel[i] == 2'b01));

        assert_mem_fwd_R3: assert property (@(posedge clk) disable iff (rst)
            (!hold_fd && mem_wen && mem_dst != '0 && mem_dst == dec_src[i]
             && !(ex_wen && ex_dst == dec_src[i]))
            |-> (src_sel[i] == 2'b10));

        assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
            src_sel[i] != 2'b11);
    end
endmodule

bind fwd_stall_unit fwd_stall_unit_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst(rst), .dec_src(dec_src), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .ex_load(ex_load), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .src_sel(src_sel), .hold_fd(hold_fd), .ex_bubble(ex_bubble)
);

// File: tb/sim_fwd_stall_unit.sv
module sim_fwd_stall_unit;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0][4:0] dec_src = '0;
    logic [4:0] ex_dst = '0, mem_dst = '0;
    logic ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0;
    logic [NS-1:0][1:0] src_sel;
    logic hold_fd, ex_bubble;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fwd_stall_unit #(.N_SRC(NS)) u0 (
        .clk(clk), .rst(rst), .dec_src(dec_src), .ex_dst(ex_dst), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .src_sel(src_sel), .hold_fd(hold_fd), .ex_bubble(ex_bubble)
    );

    function automatic logic exp_stall();
        logic s = 1'b0;
        for (int i = 0; i < NS; i++)
            if (ex_wen && ex_load && ex_dst != 0 && ex_dst == dec_src[i]) s = 1'b1;
        return s;
    endfunction

    function automatic logic [1:0] exp_sel(input int i);
        if (exp_stall()) return 2'b00;
        if (ex_wen && ex_dst != 0 && ex_dst == dec_src[i]) return 2'b01;
        if (mem_wen && mem_dst != 0 && mem_dst == dec_src[i]) return 2'b10;
        return 2'b00;
    endfunction

    task automatic apply(input logic [4:0] s0, input logic [4:0] s1,
                         input logic [4:0] ed, input logic ew, input logic el,
                         input logic [4:0] md, input logic mw);
        @(negedge clk);
        dec_src[0] = s0; dec_src[1] = s1;
        ex_dst = ed; ex_wen = ew; ex_load = el;
        mem_dst = md; mem_wen = mw;
        #2;
    endtask

    task automatic check_all(input string tag);
        logic es = exp_stall();
        for (int i = 0; i < NS; i++) begin
            logic [1:0] e = exp_sel(i);
            n_run++;
            if (src_sel[i] !== e) begin
                n_fail++;
                $display("FAIL %s src%0d sel got %b exp %b", tag, i, src_sel[i], e);
            end
        end
        n_run++;
        if (hold_fd !== es || ex_bubble !== es) begin
            n_fail++;
            $display("FAIL %s stall/bubble got %b/%b exp %b/%b", tag, hold_fd, ex_bubble, es, es);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] pool [4];
        void'($urandom(32'd1234));
        pool[0] = 5'd0; pool[1] = 5'd3; pool[2] = 5'd7; pool[3] = 5'd12;
        repeat (3) @(negedge clk);
        #2;
        check_all("R1 reset");
        @(negedge clk); rst = 1'b0;

        apply(5'd4, 5'd5, 5'd9, 1, 0, 5'd10, 1);     check_all("R1 no match");
        apply(5'd9, 5'd5, 5'd9, 1, 0, 5'd10, 1);     check_all("R2 ex alu");
        apply(5'd4, 5'd10, 5'd9, 1, 0, 5'd10, 1);    check_all("R3 mem");
        apply(5'd6, 5'd6, 5'd6, 1, 0, 5'd6, 1);      check_all("R4 youngest wins");
        apply(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1);      check_all("R5 reg zero");
        apply(5'd8, 5'd8, 5'd8, 0, 1, 5'd8, 0);      check_all("R6 no write");
        apply(5'd8, 5'd11, 5'd8, 0, 0, 5'd11, 1);    check_all("R6 ex off mem on");
        // load-use: load to r13 in execute, then it moves into memory
        apply(5'd13, 5'd2, 5'd13, 1, 1, 5'd2, 1);    check_all("R7 load use stall");
        apply(5'd13, 5'd2, 5'd0, 0, 0, 5'd13, 1);    check_all("R7 next cycle mem");
        apply(5'd2, 5'd13, 5'd13, 1, 1, 5'd0, 0);    check_all("R8 stall via src1");
        apply(5'd13, 5'd14, 5'd13, 1, 0, 5'd14, 1);  check_all("R9 independent");

        for (int k = 0; k < 2000; k++) begin
            apply(pool[$urandom_range(3)], pool[$urandom_range(3)],
                  pool[$urandom_range(3)], 1'($urandom_range(1)), 1'($urandom_range(1)),
                  pool[$urandom_range(3)], 1'($urandom_range(1)));
            check_all("R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule